// File: doc/BRIEF.md
# Secondary Interrupt Bank

This block collects up to `NUM_SRC` single-wire event sources and turns selected edges on them into latched status bits. Two separate interrupt output lines are served. Each line has its own status bits and its own mask bits. One edge-selection register is shared by both lines. Each line's active-low summary output feeds a primary aggregator, which is outside this block.

Software reaches every register through a byte-wide port with read and write strobes. A control register picks the acknowledge style. In clear-on-read style, reading a status byte acknowledges the bits it returned. In write-one-to-clear style, reads have no side effect and written ones clear status. The same register can enable a one-deep buffer per bit. It keeps a second event that arrives while the bit is still pending, so that bit has to be acknowledged twice.

The register port has no back-pressure. A read strobe is always answered exactly one cycle later with `rd_vld` high and the byte on `rdata`. A write takes effect at the clock edge that samples it.

Top module: `sih_bank`

## Requirements
- R1: Line 0 and line 1 each have their own status and mask bits. Status bytes of line 0 sit at addresses 1..NB and its mask bytes at NB+1..2NB. Line 1 status sits at 2NB+1..3NB and its mask at 3NB+1..4NB, where NB = ceil(NUM_SRC/8). Clearing or unmasking one line leaves the other line's status and summary unchanged.
- R2: The edge bytes start at address 4NB+1, four sources per byte. Source i uses byte i/4 at bit offset 2*(i mod 4). The upper bit of the pair enables rising edges, the lower bit enables falling edges, and both bits set detects either edge.
- R3: One edge configuration applies to both lines. A detected edge sets the source's status bit on both lines.
- R4: A source whose two edge bits are both 0 never sets status on either line.
- R5: `irq_n[l]` is 0 exactly when some bit is set in line l's status and clear in line l's mask. A mask bit of 1 keeps its source off that line's summary.
- R6: When control bit 0 is 1 (clear-on-read), a read of a status byte clears the bits it returned, and writes to status bytes are ignored.
- R7: When control bit 0 is 0 (write-one-to-clear), writing 1 to a status bit clears it and reading status does not change it.
- R8: When control bit 1 is 1, an edge that arrives while the bit is already set is held back and sets the bit again when the first one is cleared. When control bit 1 is 0, such an edge is dropped.
- R9: If an edge and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: After reset all mask bits read 0xFF, status and edge bytes read 0x00, control (address 0) reads 0x00, and both `irq_n` outputs are 1.
- R11: `rd_vld` goes high in the cycle after `rd_en` is sampled, with the addressed byte on `rdata`. Multi-byte registers are little-endian: source 0 is bit 0 of the lowest address.
- R12: A source pin passes through a two-stage synchronizer. A selected edge driven before clock edge k shows up on `irq_n` after edge k+2, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw event source pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 8 | Read data |
| irq_n | output | 2 | Active-low summary interrupt per line |

## Verification
The bench builds the bank with the default `NUM_SRC` of 24. That fills three whole status and mask bytes per line and six edge bytes. Sources 5, 10 and 23 therefore land in the middle edge bytes and in the top bit of the last status byte, which checks the packing arithmetic at its far end. Because there are three status bytes, the bench can leave an unmasked status bit in one byte and a masked bit in another, and so see whether the summary follows the mask. Edge timing is driven against the clock, so a clear can be placed in the very cycle a new edge is captured.

// File: rtl/sih_pkg.sv
package sih_pkg;
  localparam int LINES = 2;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_ANY  = 2'b11
  } trig_e;

  typedef struct packed {
    logic hold2;
    logic rd_ack;
  } ctrl_t;

  function automatic int sts_base(input int nb, input int line);
    return 1 + 2 * nb * line;
  endfunction

  function automatic int msk_base(input int nb, input int line);
    return 1 + nb + 2 * nb * line;
  endfunction

  function automatic int trig_base(input int nb);
    return 1 + 4 * nb;
  endfunction
endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pin,
  input  logic [NUM_SRC-1:0] rise_en,
  input  logic [NUM_SRC-1:0] fall_en,
  output logic [NUM_SRC-1:0] hit
);
  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = (rise_en[i] & sync_q[i] & ~prev_q[i]) |
                    (fall_en[i] & ~sync_q[i] & prev_q[i]);
  end
endmodule

// File: rtl/sih_line.sv
module sih_line #(
  parameter  int NUM_SRC = 24,
  localparam int NB      = (NUM_SRC + 7) / 8,
  localparam int PADW    = NB * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hit,
  input  logic [NUM_SRC-1:0] clr,
  input  logic               buf_en,
  input  logic [NB-1:0]      mask_lane,
  input  logic [7:0]         mask_byte,
  output logic [NUM_SRC-1:0] sts,
  output logic [NUM_SRC-1:0] msk,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_n
);
  logic [PADW-1:0]    msk_q;
  logic [NUM_SRC-1:0] sts_nx, pend_nx;

  always_comb begin
    sts_nx  = (sts & ~clr) | (clr & pend) | hit;
    pend_nx = buf_en ? ((pend & ~clr) | (hit & sts & (~clr | pend))) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts   <= '0;
      pend  <= '0;
      msk_q <= '1;
    end else begin
      sts  <= sts_nx;
      pend <= pend_nx;
      for (int b = 0; b < NB; b++) begin
        if (mask_lane[b]) msk_q[b*8 +: 8] <= mask_byte;
      end
    end
  end

  assign msk   = msk_q[NUM_SRC-1:0];
  assign irq_n = ~|(sts & ~msk);
endmodule

// File: rtl/sih_bank.sv
module sih_bank #(
  parameter  int NUM_SRC = 24,
  localparam int NB      = (NUM_SRC + 7) / 8,
  localparam int EB      = (NUM_SRC + 3) / 4,
  localparam int ADDR_W  = $clog2(1 + 4 * NB + EB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic               rd_vld,
  output logic [7:0]         rdata,
  output logic [1:0]         irq_n
);
  import sih_pkg::*;

  localparam int PADW = NB * 8;
  localparam int TRIG = trig_base(NB);

  ctrl_t                        ctrl_q;
  logic [EB*8-1:0]              trig_q;
  logic [NUM_SRC-1:0]           rise_en, fall_en, hit, trig_any;
  logic [1:0][NUM_SRC-1:0]      sts_w, msk_w, pend_w, clr_w;
  logic [1:0][PADW-1:0]         sts_pad, msk_pad, clr_pad;
  logic [1:0][NB-1:0]           mask_lane;
  logic [31:0]                  addr_w;
  logic [7:0]                   rd_byte;
  logic                         buf_on;

  assign addr_w = 32'(addr);
  assign buf_on = ctrl_q.hold2;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_trig
    trig_e sel;
    assign sel         = trig_e'(trig_q[2*i +: 2]);
    assign rise_en[i]  = (sel == TRIG_RISE) || (sel == TRIG_ANY);
    assign fall_en[i]  = (sel == TRIG_FALL) || (sel == TRIG_ANY);
    assign trig_any[i] = rise_en[i] | fall_en[i];
  end

  sih_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (src_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hit     (hit)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign sts_pad[l] = PADW'(sts_w[l]);
    assign msk_pad[l] = PADW'(msk_w[l]);
    assign clr_w[l]   = clr_pad[l][NUM_SRC-1:0];

    sih_line #(.NUM_SRC(NUM_SRC)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .clr       (clr_w[l]),
      .buf_en    (buf_on),
      .mask_lane (mask_lane[l]),
      .mask_byte (wdata),
      .sts       (sts_w[l]),
      .msk       (msk_w[l]),
      .pend      (pend_w[l]),
      .irq_n     (irq_n[l])
    );
  end

  // Address decode: acknowledge vectors and mask write lanes per line
  always_comb begin
    clr_pad   = '0;
    mask_lane = '0;
    for (int l = 0; l < LINES; l++) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_w == 32'(sts_base(NB, l) + b)) begin
          if (rd_en && ctrl_q.rd_ack)
            clr_pad[l][b*8 +: 8] = clr_pad[l][b*8 +: 8] | sts_pad[l][b*8 +: 8];
          if (wr_en && !ctrl_q.rd_ack)
            clr_pad[l][b*8 +: 8] = clr_pad[l][b*8 +: 8] | wdata;
        end
        if (wr_en && addr_w == 32'(msk_base(NB, l) + b))
          mask_lane[l][b] = 1'b1;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    if (addr_w == 32'd0) rd_byte = {6'd0, ctrl_q};
    for (int l = 0; l < LINES; l++) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_w == 32'(sts_base(NB, l) + b)) rd_byte = sts_pad[l][b*8 +: 8];
        if (addr_w == 32'(msk_base(NB, l) + b)) rd_byte = msk_pad[l][b*8 +: 8];
      end
    end
    for (int e = 0; e < EB; e++) begin
      if (addr_w == 32'(TRIG + e)) rd_byte = trig_q[e*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trig_q <= '0;
      rd_vld <= 1'b0;
      rdata  <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rdata <= rd_byte;
      if (wr_en) begin
        if (addr_w == 32'd0) ctrl_q <= ctrl_t'(wdata[1:0]);
        for (int e = 0; e < EB; e++) begin
          if (addr_w == 32'(TRIG + e)) trig_q[e*8 +: 8] <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/sih_bank_chk.sv
module sih_bank_chk #(
  parameter int NUM_SRC = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en,
  input logic                    rd_vld,
  input logic [1:0]              irq_n,
  input logic                    buf_on,
  input logic [NUM_SRC-1:0]      trig_any,
  input logic [1:0][NUM_SRC-1:0] sts_w,
  input logic [1:0][NUM_SRC-1:0] msk_w,
  input logic [1:0][NUM_SRC-1:0] pend_w
);
  // R5: a fully masked line never drives its summary
  a_r5_all_masked_l0: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_w[0]) |-> irq_n[0]);
  a_r5_all_masked_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_w[1]) |-> irq_n[1]);

  // R11: read data valid follows the read strobe by one cycle
  a_r11_vld_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  a_r11_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);

  // R4: no new status bit without an enabled edge or a held-back event
  a_r4_silent_src_l0: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w[0] & ~$past(sts_w[0]) & ~$past(trig_any) & ~$past(pend_w[0])) == '0);
  a_r4_silent_src_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w[1] & ~$past(sts_w[1]) & ~$past(trig_any) & ~$past(pend_w[1])) == '0);

  // R8: nothing is held back while buffering is off
  a_r8_no_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_on |=> (pend_w == '0));
endmodule

bind sih_bank sih_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_vld   (rd_vld),
  .irq_n    (irq_n),
  .buf_on   (buf_on),
  .trig_any (trig_any),
  .sts_w    (sts_w),
  .msk_w    (msk_w),
  .pend_w   (pend_w)
);

// File: tb/sim_sih_bank.sv
module sim_sih_bank;
  localparam int CLK_NS = 10;
  localparam int N      = 24;
  localparam int AW     = 5;
  localparam int A_CTRL = 0, A_S0 = 1, A_M0 = 4, A_S1 = 7, A_M1 = 10, A_TRIG = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          rd_vld;
  logic [7:0]    rdata;
  logic [1:0]    irq_n;

  always #(CLK_NS/2) clk = ~clk;

  sih_bank #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_vld(rd_vld), .rdata(rdata), .irq_n(irq_n)
  );

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input int l, input logic exp, input string tag);
    check8({7'd0, irq_n[l]}, {7'd0, exp}, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    sb.push_back('{exp, tag});
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk); src_in[i] = v;
    idle(5);
  endtask

  // Monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R11 unexpected read actual=%02h expected=none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check8(rdata, e.exp, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R10 reset state
    chk_irq(0, 1'b1, "R10 irq0 after reset");
    chk_irq(1, 1'b1, "R10 irq1 after reset");
    rd(A_M0,     8'hFF, "R10 mask0 byte0");
    rd(A_M1 + 2, 8'hFF, "R10 mask1 byte2");
    rd(A_S0 + 1, 8'h00, "R10 status0 byte1");
    rd(A_TRIG,   8'h00, "R10 edge byte0");
    rd(A_CTRL,   8'h00, "R10 control");

    // R4: source with no edge selected stays silent
    wr(A_M0, 8'h00);
    pin(0, 1'b1); pin(0, 1'b0);
    chk_irq(0, 1'b1, "R4 no edge selected irq0");
    rd(A_S0, 8'h00, "R4 no edge selected status");

    // R12 latency, rising edge on source 0
    wr(A_TRIG, 8'h02);
    @(negedge clk); src_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk_irq(0, 1'b1, "R12 not before third edge");
    @(negedge clk); chk_irq(0, 1'b0, "R12 asserted after third edge");
    idle(3);
    rd(A_S0, 8'h01, "R11 status0 byte0 little-endian");
    rd(A_S0, 8'h01, "R7 read does not clear");
    rd(A_S1, 8'h01, "R3 shared edge sets line1");
    chk_irq(1, 1'b1, "R5 masked line1 quiet");
    wr(A_S0, 8'h01);
    chk_irq(0, 1'b1, "R7 write-one clears irq0");
    rd(A_S0, 8'h00, "R7 status cleared");
    pin(0, 1'b0);
    rd(A_S0, 8'h00, "R2 rise-only ignores falling");

    // R2 packing: src5 falling, src10 both, src23 rising
    wr(A_TRIG + 1, 8'h04);
    wr(A_TRIG + 2, 8'h30);
    wr(A_TRIG + 5, 8'h80);
    pin(5, 1'b1);
    rd(A_S0, 8'h00, "R2 fall-only ignores rising");
    pin(5, 1'b0);
    rd(A_S0, 8'h20, "R2 src5 falling");
    pin(10, 1'b1);
    rd(A_S0 + 1, 8'h04, "R2 src10 rising with both");
    wr(A_S0 + 1, 8'h04);
    pin(10, 1'b0);
    rd(A_S0 + 1, 8'h04, "R2 src10 falling with both");
    pin(23, 1'b1);
    rd(A_S0 + 2, 8'h80, "R2 src23 top bit");
    rd(A_S1 + 2, 8'h80, "R3 src23 on line1");

    // R5 masking, R1 line independence
    chk_irq(0, 1'b0, "R5 unmasked status drives irq0");
    wr(A_S0, 8'h20);
    chk_irq(0, 1'b1, "R5 remaining bits masked");
    wr(A_M0 + 2, 8'h7F);
    chk_irq(0, 1'b0, "R5 unmask src23");
    wr(A_M0 + 2, 8'hFF);
    chk_irq(0, 1'b1, "R5 remask src23");
    wr(A_M1 + 2, 8'h00);
    chk_irq(1, 1'b0, "R1 line1 unmasked");
    chk_irq(0, 1'b1, "R1 line0 unaffected by line1 mask");
    wr(A_S1 + 2, 8'h80);
    chk_irq(1, 1'b1, "R1 line1 cleared");
    rd(A_S0 + 2, 8'h80, "R1 line0 status kept");

    // R6 clear-on-read
    wr(A_CTRL, 8'h01);
    rd(A_S0 + 2, 8'h80, "R6 first read returns bit");
    rd(A_S0 + 2, 8'h00, "R6 second read cleared");
    rd(A_S0 + 1, 8'h04, "R6 byte1 returned");
    rd(A_S0 + 1, 8'h00, "R6 byte1 cleared");
    pin(0, 1'b1);
    wr(A_S0, 8'hFF);
    rd(A_S0, 8'h01, "R6 status write ignored");
    rd(A_S0, 8'h00, "R6 cleared by read");

    // R8 buffered second event
    wr(A_CTRL, 8'h03);
    pin(0, 1'b0); pin(0, 1'b1); pin(0, 1'b0); pin(0, 1'b1);
    rd(A_S0, 8'h01, "R8 first event");
    rd(A_S0, 8'h01, "R8 held event reappears");
    rd(A_S0, 8'h00, "R8 cleared twice");
    wr(A_CTRL, 8'h01);
    pin(0, 1'b0); pin(0, 1'b1); pin(0, 1'b0); pin(0, 1'b1);
    rd(A_S0, 8'h01, "R8 unbuffered first event");
    rd(A_S0, 8'h00, "R8 unbuffered second dropped");

    // R9 edge and clear in the same cycle
    wr(A_CTRL, 8'h00);
    pin(0, 1'b0); pin(0, 1'b1); pin(0, 1'b0);
    rd(A_S0, 8'h01, "R9 precondition set");
    @(negedge clk); src_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = AW'(A_S0); wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    rd(A_S0, 8'h01, "R9 new edge wins over clear");
    wr(A_S0, 8'h01);
    rd(A_S0, 8'h00, "R9 plain clear");

    idle(4);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R11 missing reads actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule